// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits beside a free-running 16-bit timer counter and records the counter value when a chosen input event occurs. The event comes either from an external capture pin or from an analog comparator output. Both inputs pass through a two-stage synchronizer before an edge detector, and a control bit chooses whether rising or falling transitions count. The captured value can also be driven out as the counter's TOP limit.

A CPU reaches the unit through an 8-bit register bus. The 16-bit registers (the capture register and a read-only view of the counter) are accessed one byte at a time through a single shared high-byte staging latch, so a 16-bit value is always read or written as one consistent word. The unit also holds the timer interrupt mask and the interrupt flags, and it combines them with a global enable to produce four interrupt request lines: overflow, compare A, compare B and capture. The counter, the prescaler, the waveform outputs and interrupt vectoring are outside this block. The counter value and the overflow and compare pulses arrive as inputs.

Register addresses: 0 capture low byte, 1 capture high byte (through the latch), 2 interrupt mask, 3 interrupt flags, 4 control, 5 counter low byte, 6 counter high byte (through the latch), 7 reads zero. Control bits: bit 0 chooses the source (0 pin, 1 comparator), bit 1 chooses the edge (1 rising, 0 falling), bit 2 enables capture-as-TOP. Control bits 7..3 read 0.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture register, mask, flags and control all read 0, and every interrupt request output is low.
- R2: A selected edge on the active source loads the current counter value into the capture register and sets flag bit 3. The load happens on the third rising clock edge after the input changes, counting two synchronizer stages and one edge-detect stage.
- R3: With control bit 1 set, only rising transitions capture. With it clear, only falling transitions capture. The opposite transition leaves the capture register and flag bit 3 unchanged.
- R4: Control bit 0 picks the pin (0) or the comparator (1) as source. Transitions on the unselected source are ignored.
- R5: A read of address 0 returns the capture low byte and, in that cycle, copies the capture high byte into the shared latch. A read of address 1 returns the latch, even if a capture has changed the register since.
- R6: The latch is shared. A read of address 5 returns the counter low byte and copies the counter high byte into the latch, so a following read of address 1 or address 6 returns that counter high byte.
- R7: A write to address 1 or address 6 only loads the latch. A write to address 0 then loads the capture register with {latch, written byte} in one step. Writes to address 5 have no effect.
- R8: When a capture and a write to address 0 fall in the same cycle, the capture register takes the counter value.
- R9: The mask register at address 2 is 8 bits, read/write, reset 0. Bit 3 enables capture, bit 5 compare B, bit 6 compare A, bit 7 overflow.
- R10: Flag bits 3 (capture), 5 (compare B), 6 (compare A) and 7 (overflow) are set by their events. Writing a one to a bit clears it, writing zero does nothing, and an event in the same cycle as a clear keeps the flag set. The other flag bits read 0.
- R11: Each interrupt request is high exactly when its flag bit, its mask bit and the global enable input are all high.
- R12: With control bit 2 set, the TOP output carries the capture register and the TOP-select output is high. Otherwise the TOP output is all ones and TOP-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe (latch side effects occur at the clock edge) |
| busRdData | output | 8 | Read data, combinational from busAddr while busRdEn is high |
| cntValue | input | 16 | Current timer counter value |
| ovfPulse | input | 1 | Counter overflow pulse |
| cmpAPulse | input | 1 | Compare A match pulse |
| cmpBPulse | input | 1 | Compare B match pulse |
| capPin | input | 1 | External capture input (asynchronous) |
| acoIn | input | 1 | Comparator output capture input (asynchronous) |
| globalIntEn | input | 1 | Global interrupt enable |
| topValue | output | 16 | TOP value for the counter |
| topSel | output | 1 | High when the capture register supplies TOP |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmpA | output | 1 | Compare A interrupt request |
| irqCmpB | output | 1 | Compare B interrupt request |
| irqCap | output | 1 | Capture interrupt request |

## Verification
The hardest case is a capture that lands in exactly the same cycle as a CPU write of the capture low byte. The pin change passes through three register stages before it acts, so the bench changes the pin and then counts clock edges. It raises the write strobe so that the write meets the third edge, and it checks through the TOP output that the counter value won. The latch's stale-high-byte behaviour needs a similar sequence: a low-byte read, then a fresh capture, then a high-byte read that must still show the old byte.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [2:0] {
    ADDR_CAP_LO = 3'd0,
    ADDR_CAP_HI = 3'd1,
    ADDR_MASK   = 3'd2,
    ADDR_FLAG   = 3'd3,
    ADDR_CTRL   = 3'd4,
    ADDR_CNT_LO = 3'd5,
    ADDR_CNT_HI = 3'd6,
    ADDR_NONE   = 3'd7
  } regAddr_e;

  // Interrupt bit positions (shared by mask and flag registers)
  localparam int BIT_CAP  = 3;
  localparam int BIT_CMPB = 5;
  localparam int BIT_CMPA = 6;
  localparam int BIT_OVF  = 7;

  // Control register fields
  localparam int CTRL_SRC  = 0;
  localparam int CTRL_EDGE = 1;
  localparam int CTRL_TOP  = 2;
  localparam int CTRL_BITS = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic capEvent;     // selected capture edge this cycle
    logic loadTempWr;   // high-byte write into the shared latch
    logic loadTempCap;  // capture low read: latch capture high byte
    logic loadTempCnt;  // counter low read: latch counter high byte
    logic commitLo;     // low-byte write: commit {latch, data}
  } strobes_t;

endpackage

// File: rtl/tcap_edge.sv
module tcap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic riseSel,
  output logic edgePulse
);
  localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SW-1:0] syncQ;
  logic          prevQ;
  logic          synced;

  assign synced = syncQ[SW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= (syncQ << 1) | SW'(rawIn);
      prevQ <= synced;
    end
  end

  always_comb begin
    if (riseSel) edgePulse = synced & ~prevQ;
    else         edgePulse = ~synced & prevQ;
  end
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_SRC-1:0]  srcEdge,
  input  logic                ovfPulse,
  input  logic                cmpAPulse,
  input  logic                cmpBPulse,
  input  logic                globalIntEn,
  input  logic [CNT_W-1:0]    cntValue,
  input  logic [CNT_W-1:0]    capValue,
  input  logic [DATA_W-1:0]   tempValue,
  output strobes_t            stb,
  output logic                edgeRise,
  output logic                topSel,
  output logic [DATA_W-1:0]   flagQ,
  output logic                irqOvf,
  output logic                irqCmpA,
  output logic                irqCmpB,
  output logic                irqCap
);
  localparam logic [DATA_W-1:0] FLAG_USED =
    DATA_W'((1 << BIT_CAP) | (1 << BIT_CMPB) | (1 << BIT_CMPA) | (1 << BIT_OVF));
  localparam logic [DATA_W-1:0] CTRL_USED = DATA_W'((1 << CTRL_BITS) - 1);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  regAddr_e            addr;
  logic [DATA_W-1:0]   maskQ;
  logic [DATA_W-1:0]   ctrlQ;
  logic [DATA_W-1:0]   setVec;
  logic [DATA_W-1:0]   clrVec;
  logic [SRC_W-1:0]    srcIdx;
  logic                wrHit;
  logic                rdHit;

  assign addr  = regAddr_e'(busAddr);
  assign wrHit = busWrEn;
  assign rdHit = busRdEn;

  // Register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      ctrlQ <= '0;
    end else if (wrHit) begin
      if (addr == ADDR_MASK) maskQ <= busWrData;
      if (addr == ADDR_CTRL) ctrlQ <= busWrData & CTRL_USED;
    end
  end

  // Source selection and strobes
  assign srcIdx   = SRC_W'(ctrlQ[CTRL_SRC]);
  assign edgeRise = ctrlQ[CTRL_EDGE];
  assign topSel   = ctrlQ[CTRL_TOP];

  always_comb begin
    stb             = '0;
    stb.capEvent    = srcEdge[srcIdx];
    stb.loadTempWr  = wrHit && (addr == ADDR_CAP_HI || addr == ADDR_CNT_HI);
    stb.commitLo    = wrHit && (addr == ADDR_CAP_LO);
    stb.loadTempCap = rdHit && !wrHit && (addr == ADDR_CAP_LO);
    stb.loadTempCnt = rdHit && !wrHit && (addr == ADDR_CNT_LO);
  end

  // Flags: set has priority over write-one-to-clear
  always_comb begin
    setVec = '0;
    setVec[BIT_CAP]  = stb.capEvent;
    setVec[BIT_CMPB] = cmpBPulse;
    setVec[BIT_CMPA] = cmpAPulse;
    setVec[BIT_OVF]  = ovfPulse;
    clrVec = (wrHit && addr == ADDR_FLAG) ? busWrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= ((flagQ & ~clrVec) | setVec) & FLAG_USED;
  end

  // Interrupt requests
  assign irqCap  = flagQ[BIT_CAP]  & maskQ[BIT_CAP]  & globalIntEn;
  assign irqCmpB = flagQ[BIT_CMPB] & maskQ[BIT_CMPB] & globalIntEn;
  assign irqCmpA = flagQ[BIT_CMPA] & maskQ[BIT_CMPA] & globalIntEn;
  assign irqOvf  = flagQ[BIT_OVF]  & maskQ[BIT_OVF]  & globalIntEn;

  // Read mux
  always_comb begin
    busRdData = '0;
    if (rdHit) begin
      unique case (addr)
        ADDR_CAP_LO: busRdData = capValue[DATA_W-1:0];
        ADDR_CAP_HI: busRdData = tempValue;
        ADDR_MASK:   busRdData = maskQ;
        ADDR_FLAG:   busRdData = flagQ;
        ADDR_CTRL:   busRdData = ctrlQ;
        ADDR_CNT_LO: busRdData = cntValue[DATA_W-1:0];
        ADDR_CNT_HI: busRdData = tempValue;
        default:     busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              topSel,
  output logic [CNT_W-1:0]  capValue,
  output logic [DATA_W-1:0] tempValue,
  output logic [CNT_W-1:0]  topValue
);
  localparam int HI_LSB = CNT_W - DATA_W;

  // Shared high-byte latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tempValue <= '0;
    else if (stb.loadTempWr)  tempValue <= busWrData;
    else if (stb.loadTempCap) tempValue <= capValue[CNT_W-1:HI_LSB];
    else if (stb.loadTempCnt) tempValue <= cntValue[CNT_W-1:HI_LSB];
  end

  // Capture register: capture event beats CPU commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capValue <= '0;
    else if (stb.capEvent) capValue <= cntValue;
    else if (stb.commitLo) capValue <= {tempValue, busWrData};
  end

  assign topValue = topSel ? capValue : '1;
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic                  busRdEn,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [2*DATA_W-1:0]   cntValue,
  input  logic                  ovfPulse,
  input  logic                  cmpAPulse,
  input  logic                  cmpBPulse,
  input  logic                  capPin,
  input  logic                  acoIn,
  input  logic                  globalIntEn,
  output logic [2*DATA_W-1:0]   topValue,
  output logic                  topSel,
  output logic                  irqOvf,
  output logic                  irqCmpA,
  output logic                  irqCmpB,
  output logic                  irqCap
);
  localparam int CNT_W   = 2 * DATA_W;
  localparam int NUM_SRC = 2;

  strobes_t            stb;
  logic [CNT_W-1:0]    capValue;
  logic [DATA_W-1:0]   tempValue;
  logic [DATA_W-1:0]   flagQ;
  logic [NUM_SRC-1:0]  srcRaw;
  logic [NUM_SRC-1:0]  srcEdge;
  logic                edgeRise;

  assign srcRaw = {acoIn, capPin};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    tcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rstN(rstN), .rawIn(srcRaw[s]),
      .riseSel(edgeRise), .edgePulse(srcEdge[s])
    );
  end

  tcap_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .srcEdge(srcEdge), .ovfPulse(ovfPulse), .cmpAPulse(cmpAPulse),
    .cmpBPulse(cmpBPulse), .globalIntEn(globalIntEn), .cntValue(cntValue),
    .capValue(capValue), .tempValue(tempValue), .stb(stb),
    .edgeRise(edgeRise), .topSel(topSel), .flagQ(flagQ),
    .irqOvf(irqOvf), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqCap(irqCap)
  );

  tcap_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWrData(busWrData),
    .cntValue(cntValue), .topSel(topSel), .capValue(capValue),
    .tempValue(tempValue), .topValue(topValue)
  );
endmodule

// File: rtl/tcap_checker.sv
module tcap_checker
  import tcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input strobes_t          stb,
  input logic [CNT_W-1:0]  cntValue,
  input logic [CNT_W-1:0]  capValue,
  input logic [DATA_W-1:0] tempValue,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] flagQ,
  input logic              globalIntEn,
  input logic              irqOvf,
  input logic              irqCmpA,
  input logic              irqCmpB,
  input logic              irqCap
);
  assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capEvent |=> capValue == $past(cntValue));

  assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capEvent && stb.commitLo) |=> capValue == $past(cntValue));

  assert_commit_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitLo && !stb.capEvent) |=> capValue == {$past(tempValue), $past(busWrData)});

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commitLo && !stb.capEvent) |=> $stable(capValue));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadTempWr || stb.loadTempCap || stb.loadTempCnt) |=> $stable(tempValue));

  assert_capture_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.capEvent |=> flagQ[BIT_CAP]);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqCap || irqOvf || irqCmpA || irqCmpB) |-> globalIntEn);
endmodule

bind tcap_unit tcap_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .cntValue(cntValue), .capValue(capValue),
  .tempValue(tempValue), .busWrData(busWrData), .flagQ(flagQ),
  .globalIntEn(globalIntEn), .irqOvf(irqOvf), .irqCmpA(irqCmpA),
  .irqCmpB(irqCmpB), .irqCap(irqCap)
);

// File: tb/tcap_unit_tb.sv
`timescale 1ns/1ps
module tcap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic [15:0] cntValue = '0;
  logic        ovfPulse = 1'b0, cmpAPulse = 1'b0, cmpBPulse = 1'b0;
  logic        capPin = 1'b0, acoIn = 1'b0, globalIntEn = 1'b0;
  logic [15:0] topValue;
  logic        topSel, irqOvf, irqCmpA, irqCmpB, irqCap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tcap_unit dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .cntValue(cntValue), .ovfPulse(ovfPulse), .cmpAPulse(cmpAPulse),
    .cmpBPulse(cmpBPulse), .capPin(capPin), .acoIn(acoIn),
    .globalIntEn(globalIntEn), .topValue(topValue), .topSel(topSel),
    .irqOvf(irqOvf), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqCap(irqCap)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic readCap(output logic [15:0] v);
    logic [7:0] lo, hi;
    busRead(3'd0, lo);
    busRead(3'd1, hi);
    v = {hi, lo};
  endtask

  // Drive a source and wait past the three-edge capture latency
  task automatic driveSrc(input bit useAco, input logic v);
    @(negedge clk);
    if (useAco) acoIn = v; else capPin = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    logic [15:0] c;
    readCap(c);          check("R1 capture", c, 16'h0000);
    busRead(3'd2, d);    check("R1 mask", d, 8'h00);
    busRead(3'd3, d);    check("R1 flags", d, 8'h00);
    busRead(3'd4, d);    check("R1 control", d, 8'h00);
    check("R1 irqs", {irqOvf, irqCmpA, irqCmpB, irqCap}, 4'h0);
  endtask

  task automatic test_mask();
    logic [7:0] d;
    busWrite(3'd2, 8'hFF); busRead(3'd2, d); check("R9 mask all ones", d, 8'hFF);
    busWrite(3'd2, 8'hA5); busRead(3'd2, d); check("R9 mask pattern", d, 8'hA5);
  endtask

  task automatic test_capture_timing();
    logic [15:0] c;
    busWrite(3'd4, 8'h02);
    busWrite(3'd2, 8'h08);
    globalIntEn = 1'b1;
    cntValue = 16'h1234;
    @(negedge clk); capPin = 1'b1;
    @(posedge clk); #1; check("R2 no capture after edge 1", irqCap, 1'b0);
    @(posedge clk); #1; check("R2 no capture after edge 2", irqCap, 1'b0);
    @(posedge clk); #1; check("R2 capture after edge 3", irqCap, 1'b1);
    readCap(c); check("R2 captured value", c, 16'h1234);
    globalIntEn = 1'b0;
  endtask

  task automatic test_edge_select();
    logic [7:0] d;
    logic [15:0] c;
    busWrite(3'd3, 8'hFF);
    cntValue = 16'h7777;
    driveSrc(1'b0, 1'b0);
    busRead(3'd3, d); check("R3 falling ignored in rising mode", d, 8'h00);
    readCap(c);       check("R3 capture unchanged", c, 16'h1234);
    busWrite(3'd4, 8'h00);
    driveSrc(1'b0, 1'b1);
    busRead(3'd3, d); check("R3 rising ignored in falling mode", d, 8'h00);
    cntValue = 16'hBEEF;
    driveSrc(1'b0, 1'b0);
    busRead(3'd3, d); check("R3 falling captures flag", d, 8'h08);
    readCap(c);       check("R3 falling captures value", c, 16'hBEEF);
  endtask

  task automatic test_source();
    logic [7:0] d;
    logic [15:0] c;
    busWrite(3'd3, 8'hFF);
    busWrite(3'd4, 8'h02);
    cntValue = 16'h5555;
    driveSrc(1'b1, 1'b1);
    busRead(3'd3, d); check("R4 comparator ignored with pin selected", d, 8'h00);
    busWrite(3'd4, 8'h03);
    driveSrc(1'b1, 1'b0);
    driveSrc(1'b1, 1'b1);
    readCap(c); check("R4 comparator capture", c, 16'h5555);
    cntValue = 16'h6666;
    driveSrc(1'b0, 1'b1);
    readCap(c); check("R4 pin ignored with comparator selected", c, 16'h5555);
  endtask

  task automatic test_latch_consistency();
    logic [7:0] d;
    logic [15:0] c;
    busWrite(3'd4, 8'h02);
    driveSrc(1'b0, 1'b0);
    busRead(3'd0, d); check("R5 low byte", d, 8'h55);
    cntValue = 16'hC3D2;
    driveSrc(1'b0, 1'b1);
    busRead(3'd1, d); check("R5 high byte from latch is stale", d, 8'h55);
    readCap(c);       check("R5 fresh word", c, 16'hC3D2);
  endtask

  task automatic test_shared_latch();
    logic [7:0] d;
    cntValue = 16'h9A7B;
    busRead(3'd5, d); check("R6 counter low", d, 8'h7B);
    busRead(3'd1, d); check("R6 capture high shows counter high", d, 8'h9A);
    busRead(3'd6, d); check("R6 counter high", d, 8'h9A);
  endtask

  task automatic test_write_top();
    busWrite(3'd4, 8'h00);
    check("R12 top off value", topValue, 16'hFFFF);
    check("R12 top off select", topSel, 1'b0);
    busWrite(3'd4, 8'h04);
    check("R12 top on select", topSel, 1'b1);
    check("R12 top tracks capture", topValue, 16'hC3D2);
    busWrite(3'd1, 8'h7E);
    check("R7 high write alone no change", topValue, 16'hC3D2);
    busWrite(3'd5, 8'h99);
    check("R7 counter low write ignored", topValue, 16'hC3D2);
    busWrite(3'd0, 8'h11);
    check("R7 low write commits word", topValue, 16'h7E11);
  endtask

  task automatic test_priority();
    busWrite(3'd4, 8'h06);
    driveSrc(1'b0, 1'b0);
    cntValue = 16'h2468;
    busWrite(3'd1, 8'h44);
    @(negedge clk); capPin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); busAddr = 3'd0; busWrData = 8'h55; busWrEn = 1'b1;
    @(posedge clk); #1; busWrEn = 1'b0;
    check("R8 capture beats write", topValue, 16'h2468);
    busWrite(3'd0, 8'h55);
    check("R7 later write commits latch", topValue, 16'h4455);
  endtask

  task automatic test_flags();
    logic [7:0] d;
    busWrite(3'd3, 8'hFF);
    busRead(3'd3, d); check("R10 cleared", d, 8'h00);
    @(negedge clk); ovfPulse = 1'b1; @(negedge clk); ovfPulse = 1'b0;
    cmpAPulse = 1'b1; @(negedge clk); cmpAPulse = 1'b0;
    cmpBPulse = 1'b1; @(negedge clk); cmpBPulse = 1'b0;
    busRead(3'd3, d); check("R10 event flags", d, 8'hE0);
    busWrite(3'd3, 8'h40);
    busRead(3'd3, d); check("R10 write one clears only that bit", d, 8'hA0);
    busWrite(3'd3, 8'h00);
    busRead(3'd3, d); check("R10 write zero no effect", d, 8'hA0);
    @(negedge clk); busAddr = 3'd3; busWrData = 8'h80; busWrEn = 1'b1; ovfPulse = 1'b1;
    @(posedge clk); #1; busWrEn = 1'b0; ovfPulse = 1'b0;
    busRead(3'd3, d); check("R10 set beats clear", d, 8'hA0);
  endtask

  task automatic test_irq();
    busWrite(3'd2, 8'h20);
    globalIntEn = 1'b0; #1;
    check("R11 global off", {irqOvf, irqCmpA, irqCmpB, irqCap}, 4'h0);
    globalIntEn = 1'b1; #1;
    check("R11 only compare B", {irqOvf, irqCmpA, irqCmpB, irqCap}, 4'h2);
    busWrite(3'd2, 8'hA0);
    check("R11 overflow and compare B", {irqOvf, irqCmpA, irqCmpB, irqCap}, 4'hA);
    busWrite(3'd3, 8'hFF);
    check("R11 flags cleared", {irqOvf, irqCmpA, irqCmpB, irqCap}, 4'h0);
    globalIntEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    test_reset();
    test_mask();
    test_capture_timing();
    test_edge_select();
    test_source();
    test_latch_consistency();
    test_shared_latch();
    test_write_top();
    test_priority();
    test_flags();
    test_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule